// File: doc/BRIEF.md
# Byte-Stepped I2C Bus Master

This block is an I2C bus master that a host processor steps one bus phase at a time through a small register file. The host sets control bits to request a START, a byte transfer or a STOP. When the phase is over, the master raises an event flag and loads a single 8-bit event code that names what just happened on the bus. The host decides the next phase and then clears the flag. Clearing the flag is the only thing that lets the master leave a phase. While the flag stands and the master owns the bus, SCL is held low.

The bus pins are open-drain: an `_oe` output at 1 pulls the line low. A programmable prescaler divides the system clock into a quarter-bit tick, and every bus bit lasts four ticks. The block also detects lost arbitration, can generate a repeated START, and returns an ACK or a NACK on received bytes according to a host control bit. Register word indices: 0 control, 1 event code, 2 data, 3 prescaler, 4 soft reset, 5 own address, 6 extended address.

Top module: `i2c_step_master`

## Requirements
- R1: After reset the event code reads 0xF8, the control register reads 0x00 and the prescaler reads its reset value (3).
- R2: Control bits are: bit 7 interrupt enable, bit 6 core enable, bit 5 start, bit 4 stop, bit 3 event flag, bit 2 acknowledge select. With core enable at 1, setting start on an idle bus makes a START condition, sets the flag, gives code 0x08 and clears the start bit. With core enable at 0, start does nothing.
- R3: Start requested while the bus is still owned, together with a flag clear, gives a repeated START and code 0x10.
- R4: After a START code, clearing the flag sends the data register MSB first as the address byte. Bit 0 of that byte is the direction. The resulting code is 0x18 for write with ACK, 0x20 for write with NACK, 0x40 for read with ACK and 0x48 for read with NACK.
- R5: After a write-direction code, clearing the flag sends the data register MSB first. The code is 0x28 if the target acknowledges and 0x30 if it does not.
- R6: After a read-direction code, clearing the flag receives a byte into the data register. With acknowledge select at 1 the master drives ACK and the code is 0x50. With it at 0 the master drives NACK and the code is 0x58.
- R7: If SDA reads low while the master is sending a 1 bit, the master releases SCL and SDA at once and reports code 0x38 with the flag set. Clearing the flag then gives code 0xF8.
- R8: Stop together with a flag clear makes a STOP condition. The code then becomes 0xF8, the flag stays 0, the stop bit clears, and both lines are released.
- R9: While the flag is set and the bus is owned, SCL is held low and no bus phase starts.
- R10: The interrupt output is high exactly when interrupt enable and the event flag are both 1.
- R11: Writing 1 to the flag bit does not set it, and writes to the event-code register have no effect.
- R12: SCL stays high for 2*(P+1) system clocks in each data and acknowledge bit, where P is the prescaler value.
- R13: A write of any value to the soft-reset word returns every register to its reset value, including the event code at 0xF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 3 | Register word index |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| irq_o | output | 1 | Interrupt request |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |

## Verification
The bench attaches a behavioural target and a rival bus driver to the open-drain lines. It walks through every event code, each with the expected bytes seen on the wire. Some mistakes it looks for:
- Treating the repeated START like a first START would report 0x08 instead of 0x10.
- Taking the direction bit from the wrong place would flip the 0x18/0x40 family.
- Mixing up the acknowledge select would swap 0x50 and 0x58, and the target would see the wrong ACK.

The bench also checks that SCL stays low across a long wait with the flag set; a design that leaks a clock there would shift a phantom bit. Two prescaler values are tried, and a design that forgets the +1 would fail the measured SCL high width. For arbitration loss it checks that both pins are released; a master that still drives them would corrupt the winner's transfer.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {BC_START, BC_STOP, BC_WRITE, BC_READ} bit_cmd_e;

  typedef enum logic [2:0] {
    FS_IDLE, FS_START, FS_TX, FS_TXACK, FS_RX, FS_RXACK, FS_STOP, FS_WAIT
  } fsm_e;

  // event codes reported to the host
  localparam logic [7:0] EV_START   = 8'h08;
  localparam logic [7:0] EV_RSTART  = 8'h10;
  localparam logic [7:0] EV_AW_ACK  = 8'h18;
  localparam logic [7:0] EV_AW_NACK = 8'h20;
  localparam logic [7:0] EV_DW_ACK  = 8'h28;
  localparam logic [7:0] EV_DW_NACK = 8'h30;
  localparam logic [7:0] EV_ARB     = 8'h38;
  localparam logic [7:0] EV_AR_ACK  = 8'h40;
  localparam logic [7:0] EV_AR_NACK = 8'h48;
  localparam logic [7:0] EV_DR_ACK  = 8'h50;
  localparam logic [7:0] EV_DR_NACK = 8'h58;
  localparam logic [7:0] EV_IDLE    = 8'hF8;

  // control bit positions
  localparam int CB_IEN  = 7;
  localparam int CB_EN   = 6;
  localparam int CB_STA  = 5;
  localparam int CB_STO  = 4;
  localparam int CB_IFLG = 3;
  localparam int CB_AAK  = 2;

  // register word indices
  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_EVENT = 3'd1;
  localparam logic [2:0] RA_DATA  = 3'd2;
  localparam logic [2:0] RA_PRESC = 3'd3;
  localparam logic [2:0] RA_SRST  = 3'd4;
  localparam logic [2:0] RA_OWN   = 3'd5;
  localparam logic [2:0] RA_EXT   = 3'd6;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [PW-1:0] presc_i,
  output logic          tick_o
);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= presc_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end

  p_tick_gap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && presc_i != '0 && !clr_i) |=> !tick_o);
endmodule

// File: rtl/i2cm_bit.sv
module i2cm_bit
  import i2cm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     tick_i,
  input  logic     cmd_valid_i,
  input  bit_cmd_e cmd_i,
  input  logic     wbit_i,
  input  logic     arb_chk_i,
  input  logic     sda_i,
  output logic     done_o,
  output logic     lost_o,
  output logic     rbit_o,
  output logic     scl_low_o,
  output logic     sda_low_o
);
  logic     active_q, wbit_q, chk_q;
  logic [1:0] phase_q;
  bit_cmd_e cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0; wbit_q <= 1'b0; chk_q <= 1'b0; phase_q <= '0;
      cmd_q <= BC_STOP; done_o <= 1'b0; lost_o <= 1'b0; rbit_o <= 1'b0;
      scl_low_o <= 1'b0; sda_low_o <= 1'b0;
    end else if (clr_i) begin
      active_q <= 1'b0; wbit_q <= 1'b0; chk_q <= 1'b0; phase_q <= '0;
      cmd_q <= BC_STOP; done_o <= 1'b0; lost_o <= 1'b0; rbit_o <= 1'b0;
      scl_low_o <= 1'b0; sda_low_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      lost_o <= 1'b0;
      if (!active_q && cmd_valid_i) begin
        active_q <= 1'b1;
        phase_q  <= '0;
        cmd_q    <= cmd_i;
        wbit_q   <= wbit_i;
        chk_q    <= arb_chk_i;
      end else if (active_q && tick_i) begin
        phase_q <= phase_q + 1'b1;
        unique case (cmd_q)
          BC_START: begin
            unique case (phase_q)
              2'd0: sda_low_o <= 1'b0;
              2'd1: scl_low_o <= 1'b0;
              2'd2: sda_low_o <= 1'b1;
              default: begin scl_low_o <= 1'b1; active_q <= 1'b0; done_o <= 1'b1; end
            endcase
          end
          BC_STOP: begin
            unique case (phase_q)
              2'd0: sda_low_o <= 1'b1;
              2'd1: scl_low_o <= 1'b0;
              2'd2: sda_low_o <= 1'b0;
              default: begin active_q <= 1'b0; done_o <= 1'b1; end
            endcase
          end
          default: begin
            unique case (phase_q)
              2'd0: sda_low_o <= (cmd_q == BC_WRITE) ? !wbit_q : 1'b0;
              2'd1: scl_low_o <= 1'b0;
              2'd2: begin
                rbit_o <= sda_i;
                if (cmd_q == BC_WRITE && chk_q && wbit_q && !sda_i) begin
                  scl_low_o <= 1'b0;
                  sda_low_o <= 1'b0;
                  active_q  <= 1'b0;
                  lost_o    <= 1'b1;
                end
              end
              default: begin scl_low_o <= 1'b1; active_q <= 1'b0; done_o <= 1'b1; end
            endcase
          end
        endcase
      end
    end
  end

  // data bits only change SDA while SCL is held low
  p_sda_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (active_q && (cmd_q == BC_WRITE || cmd_q == BC_READ) && !scl_low_o) |-> $stable(sda_low_o));
  p_done_lost_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && lost_o));
endmodule

// File: rtl/i2c_step_master.sv
module i2c_step_master
  import i2cm_pkg::*;
#(
  parameter int          PRESC_W   = 8,
  parameter logic [7:0]  PRESC_RST = 8'd3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] reg_addr_i,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_o,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic ien_q, en_q, sta_q, sto_q, iflg_q, aak_q, owned_q, is_addr_q, go_q;
  logic [7:0] status_q, data_q, own_q, ext_q;
  logic [BYTE_W-1:0] shift_q;
  logic [PRESC_W-1:0] presc_q;
  logic [CNT_W-1:0] bit_cnt_q;
  fsm_e state_q;

  logic srst, ctrl_we, clear_ev, tick, eng_done, eng_lost, eng_rbit;
  logic cmd_wbit, arb_chk, tx_group, start_group;
  bit_cmd_e cmd;

  assign srst     = reg_we_i && reg_addr_i == RA_SRST;
  assign ctrl_we  = reg_we_i && reg_addr_i == RA_CTRL;
  assign clear_ev = ctrl_we && iflg_q && !reg_wdata_i[CB_IFLG];
  assign start_group = status_q == EV_START || status_q == EV_RSTART;
  assign tx_group = status_q == EV_AW_ACK || status_q == EV_AW_NACK ||
                    status_q == EV_DW_ACK || status_q == EV_DW_NACK;

  always_comb begin
    cmd      = BC_READ;
    cmd_wbit = 1'b1;
    arb_chk  = 1'b0;
    unique case (state_q)
      FS_START: cmd = BC_START;
      FS_STOP:  cmd = BC_STOP;
      FS_TX:    begin cmd = BC_WRITE; cmd_wbit = shift_q[BYTE_W-1]; arb_chk = 1'b1; end
      FS_RXACK: begin cmd = BC_WRITE; cmd_wbit = !aak_q; end
      default:  cmd = BC_READ;
    endcase
  end

  i2cm_tick #(.PW(PRESC_W)) u_tick (
    .clk_i, .rst_ni, .clr_i(srst), .presc_i(presc_q), .tick_o(tick)
  );

  i2cm_bit u_bit (
    .clk_i, .rst_ni, .clr_i(srst), .tick_i(tick), .cmd_valid_i(go_q),
    .cmd_i(cmd), .wbit_i(cmd_wbit), .arb_chk_i(arb_chk), .sda_i,
    .done_o(eng_done), .lost_o(eng_lost), .rbit_o(eng_rbit),
    .scl_low_o(scl_oe_o), .sda_low_o(sda_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {ien_q, en_q, sta_q, sto_q, iflg_q, aak_q, owned_q, is_addr_q, go_q} <= '0;
      status_q <= EV_IDLE; data_q <= '0; own_q <= '0; ext_q <= '0;
      shift_q <= '0; presc_q <= PRESC_RST; bit_cnt_q <= '0; state_q <= FS_IDLE;
    end else if (srst) begin
      {ien_q, en_q, sta_q, sto_q, iflg_q, aak_q, owned_q, is_addr_q, go_q} <= '0;
      status_q <= EV_IDLE; data_q <= '0; own_q <= '0; ext_q <= '0;
      shift_q <= '0; presc_q <= PRESC_RST; bit_cnt_q <= '0; state_q <= FS_IDLE;
    end else begin
      go_q <= 1'b0;
      if (ctrl_we) begin
        ien_q <= reg_wdata_i[CB_IEN];
        en_q  <= reg_wdata_i[CB_EN];
        sta_q <= reg_wdata_i[CB_STA];
        sto_q <= reg_wdata_i[CB_STO];
        aak_q <= reg_wdata_i[CB_AAK];
        if (!reg_wdata_i[CB_IFLG]) iflg_q <= 1'b0;
      end
      if (reg_we_i && reg_addr_i == RA_DATA)  data_q  <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == RA_PRESC) presc_q <= reg_wdata_i[PRESC_W-1:0];
      if (reg_we_i && reg_addr_i == RA_OWN)   own_q   <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == RA_EXT)   ext_q   <= reg_wdata_i;

      unique case (state_q)
        FS_IDLE: if (en_q && sta_q) begin state_q <= FS_START; go_q <= 1'b1; end
        FS_START: if (eng_done) begin
          status_q <= owned_q ? EV_RSTART : EV_START;
          owned_q  <= 1'b1;
          sta_q    <= 1'b0;
          iflg_q   <= 1'b1;
          state_q  <= FS_WAIT;
        end
        FS_WAIT: if (clear_ev) begin
          bit_cnt_q <= '0;
          if (!owned_q) begin
            if (reg_wdata_i[CB_EN] && reg_wdata_i[CB_STA]) begin
              state_q <= FS_START; go_q <= 1'b1;
            end else begin
              status_q <= EV_IDLE; state_q <= FS_IDLE;
            end
          end else if (reg_wdata_i[CB_STA]) begin
            state_q <= FS_START; go_q <= 1'b1;
          end else if (reg_wdata_i[CB_STO]) begin
            state_q <= FS_STOP; go_q <= 1'b1;
          end else if (start_group || tx_group) begin
            shift_q   <= data_q;
            is_addr_q <= start_group;
            state_q   <= FS_TX; go_q <= 1'b1;
          end else begin
            state_q <= FS_RX; go_q <= 1'b1;
          end
        end
        FS_TX: if (eng_lost) begin
          status_q <= EV_ARB; owned_q <= 1'b0; iflg_q <= 1'b1; state_q <= FS_WAIT;
        end else if (eng_done) begin
          shift_q   <= {shift_q[BYTE_W-2:0], 1'b0};
          bit_cnt_q <= bit_cnt_q + 1'b1;
          go_q      <= 1'b1;
          if (bit_cnt_q == CNT_W'(BYTE_W-1)) state_q <= FS_TXACK;
        end
        FS_TXACK: if (eng_done) begin
          if (is_addr_q) begin
            if (data_q[0]) status_q <= eng_rbit ? EV_AR_NACK : EV_AR_ACK;
            else           status_q <= eng_rbit ? EV_AW_NACK : EV_AW_ACK;
          end else begin
            status_q <= eng_rbit ? EV_DW_NACK : EV_DW_ACK;
          end
          iflg_q  <= 1'b1;
          state_q <= FS_WAIT;
        end
        FS_RX: if (eng_done) begin
          shift_q   <= {shift_q[BYTE_W-2:0], eng_rbit};
          bit_cnt_q <= bit_cnt_q + 1'b1;
          go_q      <= 1'b1;
          if (bit_cnt_q == CNT_W'(BYTE_W-1)) state_q <= FS_RXACK;
        end
        FS_RXACK: if (eng_done) begin
          data_q   <= shift_q;
          status_q <= aak_q ? EV_DR_ACK : EV_DR_NACK;
          iflg_q   <= 1'b1;
          state_q  <= FS_WAIT;
        end
        FS_STOP: if (eng_done) begin
          owned_q  <= 1'b0;
          sto_q    <= 1'b0;
          status_q <= EV_IDLE;
          state_q  <= FS_IDLE;
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      RA_CTRL:  reg_rdata_o = {ien_q, en_q, sta_q, sto_q, iflg_q, aak_q, 2'b00};
      RA_EVENT: reg_rdata_o = status_q;
      RA_DATA:  reg_rdata_o = data_q;
      RA_PRESC: reg_rdata_o = 8'(presc_q);
      RA_OWN:   reg_rdata_o = own_q;
      RA_EXT:   reg_rdata_o = ext_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o = ien_q & iflg_q;

  p_hold_scl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iflg_q && owned_q) |-> scl_oe_o);
  p_no_phase_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iflg_q |-> !go_q);
  p_start_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == FS_START && eng_done && !srst) |=> (status_q == EV_START || status_q == EV_RSTART));
  p_lost_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_lost |-> (!scl_oe_o && !sda_oe_o));
  p_stop_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == FS_STOP && eng_done && !srst) |=> (status_q == EV_IDLE && !owned_q));
endmodule

// File: tb/i2c_step_master_bench.sv
`timescale 1ns/1ps
module i2c_step_master_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq, scl_oe, sda_oe;
  logic sl_low = 1'b0, rival_low = 1'b0, ack_en = 1'b1;
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || sl_low || rival_low);

  int checks = 0, errors = 0;
  localparam logic [6:0] SLV = 7'h5A;

  always #5 clk = !clk;

  i2c_step_master u_i2c_step_master (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .sda_i(sda_line), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  // behavioural target
  int bitc = -1, starts = 0, stops = 0;
  bit sl_active = 0, addr_ph = 0, addr_done = 0, matched = 0, rdm = 0, stop_tx = 0, master_ack = 0;
  logic [7:0] rx_sh = '0, last_rx = '0, tx_sh = '0, tx_next = '0;
  time t_rise = 0;
  int hi_len = 0;

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    sl_active = 1; bitc = -1; addr_ph = 1; addr_done = 0; matched = 0;
    rdm = 0; stop_tx = 0; sl_low = 0; starts++;
  end
  always @(posedge sda_line) if (scl_line === 1'b1) begin
    if (sl_active) stops++;
    sl_active = 0; sl_low = 0;
  end
  always @(posedge scl_line) begin
    t_rise = $time;
    if (sl_active && bitc >= 0) begin
      if (bitc < 8) rx_sh = {rx_sh[6:0], sda_line};
      else if (!addr_ph && rdm && matched) begin
        master_ack = !sda_line;
        if (!master_ack) stop_tx = 1;
      end
    end
  end
  always @(negedge scl_line) begin
    hi_len = int'(($time - t_rise) / 10);
    if (sl_active) begin
      bitc = bitc + 1;
      if (bitc == 9) bitc = 0;
      if (bitc == 8) begin
        if (addr_ph) begin
          matched = rx_sh[7:1] == SLV; rdm = rx_sh[0]; last_rx = rx_sh;
          sl_low = matched && ack_en; addr_done = 1;
        end else if (!rdm) begin
          last_rx = rx_sh; sl_low = matched && ack_en;
        end else sl_low = 0;
      end else if (bitc == 0) begin
        if (addr_done) begin addr_ph = 0; addr_done = 0; end
        sl_low = 0;
        if (!addr_ph && rdm && matched && !stop_tx) begin
          tx_sh = tx_next; sl_low = !tx_sh[7];
        end
      end else begin
        sl_low = (!addr_ph && rdm && matched && !stop_tx) ? !tx_sh[7-bitc] : 1'b0;
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_flag(input string req);
    logic [7:0] c;
    for (int i = 0; i < 4000; i++) begin
      rd(3'd0, c);
      if (c[3]) return;
    end
    chk(0, {req, " flag timeout"}, 0, 1);
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(3'd1, s);
      if (s == 8'hF8) return;
    end
    chk(0, {req, " idle timeout"}, 0, 8'hF8);
  endtask

  task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string req);
    logic [7:0] v;
    rd(a, v);
    chk(v == e, req, v, e);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_reg(3'd1, 8'hF8, "R1 event code");
    expect_reg(3'd0, 8'h00, "R1 control");
    expect_reg(3'd3, 8'h03, "R1 prescaler");

    // R2 start ignored without core enable
    wr(3'd0, 8'h20);
    repeat (60) @(negedge clk);
    expect_reg(3'd1, 8'hF8, "R2 no start when disabled");
    chk(scl_line == 1'b1 && starts == 0, "R2 bus untouched", starts, 0);

    // R2 start
    wr(3'd0, 8'h60);
    wait_flag("R2");
    expect_reg(3'd1, 8'h08, "R2 start code");
    expect_reg(3'd0, 8'h48, "R2 start bit cleared");
    chk(starts == 1, "R2 START on bus", starts, 1);
    // R9 SCL held low, no phase while flag stands
    repeat (200) @(negedge clk);
    chk(scl_line == 1'b0, "R9 scl held low", scl_line, 0);
    expect_reg(3'd1, 8'h08, "R9 no phase while flag set");
    // R10 / R11
    chk(irq == 1'b0, "R10 irq off without enable", irq, 0);
    wr(3'd0, 8'hC8);
    @(negedge clk);
    chk(irq == 1'b1, "R10 irq on", irq, 1);
    wr(3'd0, 8'h48);
    @(negedge clk);
    chk(irq == 1'b0, "R10 irq off after disable", irq, 0);
    expect_reg(3'd0, 8'h48, "R11 flag kept by write of 1");

    // R4 write address with ACK
    wr(3'd2, {SLV, 1'b0});
    wr(3'd0, 8'h40);
    wait_flag("R4");
    expect_reg(3'd1, 8'h18, "R4 write addr ack");
    chk(last_rx == {SLV, 1'b0}, "R4 addr byte on bus", last_rx, {SLV, 1'b0});
    chk(hi_len == 8, "R12 scl high P=3", hi_len, 8);

    // R5 data transmit ack / nack
    wr(3'd2, 8'h3C);
    wr(3'd0, 8'h40);
    wait_flag("R5");
    expect_reg(3'd1, 8'h28, "R5 data ack");
    chk(last_rx == 8'h3C, "R5 data byte on bus", last_rx, 8'h3C);
    ack_en = 1'b0;
    wr(3'd2, 8'hC3);
    wr(3'd0, 8'h40);
    wait_flag("R5");
    expect_reg(3'd1, 8'h30, "R5 data nack");
    chk(last_rx == 8'hC3, "R5 second byte on bus", last_rx, 8'hC3);
    ack_en = 1'b1;

    // R3 repeated start
    wr(3'd0, 8'h60);
    wait_flag("R3");
    expect_reg(3'd1, 8'h10, "R3 repeated start code");
    chk(starts == 2, "R3 second START on bus", starts, 2);

    // R4 read address, R6 receive
    tx_next = 8'hA7;
    wr(3'd2, {SLV, 1'b1});
    wr(3'd0, 8'h40);
    wait_flag("R4");
    expect_reg(3'd1, 8'h40, "R4 read addr ack");
    tx_next = 8'h5E;
    wr(3'd0, 8'h44);
    wait_flag("R6");
    expect_reg(3'd1, 8'h50, "R6 receive with ack");
    expect_reg(3'd2, 8'hA7, "R6 received byte");
    chk(master_ack == 1, "R6 ack driven", master_ack, 1);
    wr(3'd0, 8'h40);
    wait_flag("R6");
    expect_reg(3'd1, 8'h58, "R6 receive with nack");
    expect_reg(3'd2, 8'h5E, "R6 second received byte");
    chk(master_ack == 0, "R6 nack driven", master_ack, 0);

    // R8 stop
    s0 = stops;
    wr(3'd0, 8'h50);
    wait_idle("R8");
    expect_reg(3'd0, 8'h40, "R8 flag and stop clear");
    chk(stops == s0 + 1, "R8 STOP on bus", stops, s0 + 1);
    chk(scl_line && sda_line, "R8 lines released", {scl_line, sda_line}, 3);

    // R11 event register write ignored
    wr(3'd1, 8'h00);
    expect_reg(3'd1, 8'hF8, "R11 event write ignored");

    // R4 nacked addresses, R12 with P=1
    wr(3'd3, 8'h01);
    wr(3'd0, 8'h60);
    wait_flag("R4");
    wr(3'd2, 8'h22);
    wr(3'd0, 8'h40);
    wait_flag("R4");
    expect_reg(3'd1, 8'h20, "R4 write addr nack");
    chk(hi_len == 4, "R12 scl high P=1", hi_len, 4);
    wr(3'd0, 8'h60);
    wait_flag("R3");
    expect_reg(3'd1, 8'h10, "R3 repeated start after nack");
    wr(3'd2, 8'h23);
    wr(3'd0, 8'h40);
    wait_flag("R4");
    expect_reg(3'd1, 8'h48, "R4 read addr nack");
    wr(3'd0, 8'h50);
    wait_idle("R8");

    // R7 arbitration loss
    wr(3'd0, 8'h60);
    wait_flag("R7");
    wr(3'd2, {SLV, 1'b0});
    rival_low = 1'b1;
    wr(3'd0, 8'h40);
    wait_flag("R7");
    expect_reg(3'd1, 8'h38, "R7 arbitration code");
    chk(!scl_oe && !sda_oe, "R7 pins released", {scl_oe, sda_oe}, 0);
    rival_low = 1'b0;
    wr(3'd0, 8'h40);
    repeat (4) @(negedge clk);
    expect_reg(3'd1, 8'hF8, "R7 idle after clear");

    // R13 soft reset
    wr(3'd3, 8'h09);
    wr(3'd5, 8'h12);
    wr(3'd0, 8'h80);
    wr(3'd4, 8'h5A);
    expect_reg(3'd0, 8'h00, "R13 control cleared");
    expect_reg(3'd3, 8'h03, "R13 prescaler restored");
    expect_reg(3'd5, 8'h00, "R13 own address cleared");
    expect_reg(3'd1, 8'hF8, "R13 event idle");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule